// File: doc/BRIEF.md
# Adaptive Segmented DAC Data Splitter

This block takes a signed quantizer code on each valid sample and splits it into three signed sub-words. The sub-words drive unit-element DACs of weight 1, 4 and 16, and their weighted sum equals the input code on every sample. The 16x path carries the bulk of the signal. Each of the 16x and 4x stages rounds what it receives to a multiple of its weight and carries its rounding error into the next sample. As a result, the lower-weight paths only ever carry first-order noise-shaped residue.

A peak envelope follower watches the magnitude of the incoming code and sets how many segments are in use. In small-signal mode only the 1x path is used, so the mismatch between DAC segments disappears at low amplitude. Mid mode uses the 1x and 4x paths, and large mode uses all three. Each unused segment outputs zero and raises its power-down flag.

A mode moves up in the same sample in which the envelope crosses its threshold. It moves down one mode at a time, and only after the envelope has stayed below the lower threshold, less a hysteresis margin, for a run of consecutive samples. When the 16x stage is dropped, its carried error is not lost: it is added into the 4x stage's carried error.

Top module: `dac_seg_split`

## Requirements
- R1: On every output sample, 16*seg16_o + 4*seg4_o + seg1_o (each read as a DW-bit two's complement value) equals the input code of the sample that produced it.
- R2: In large mode the 16x stage computes v = code + c16, where c16 is its carried error. It outputs floor((v+8)/16) and keeps v - 16*seg16 as the next c16. The 4x stage does the same with weight 4, rounding constant 2 and carried error c4 on r = code - 16*seg16. The 1x path gets r - 4*seg4.
- R3: In small mode seg1_o equals the code, seg4_o = seg16_o = 0, and pd4_o = pd16_o = 1.
- R4: In mid mode seg16_o = 0 and pd16_o = 1, pd4_o = 0. The 4x stage works as in R2 on the full code, and the 1x path takes the rest.
- R5: The mode applied to a sample is the larger of the stored mode and the mode demanded by peak = max(envelope, |code|). A peak above T2 demands large mode, a peak above T1 demands mid mode. The flags use pd4_o = 1 when the 4x segment is off and pd16_o = 1 when the 16x segment is off.
- R6: The envelope takes |code| immediately when |code| is at least the envelope. Otherwise it falls by one on every 2^K-th valid sample, counted by a free-running counter of valid samples.
- R7: The stored mode drops by exactly one step after HOLD consecutive valid samples in which no upshift is demanded and peak + HYST <= the threshold below it (T2 from large mode, T1 from mid mode). Any sample that breaks this condition restarts the count.
- R8: On a drop from large to mid mode, the 16x carried error is added to the 4x carried error and c16 is cleared. On a drop from mid to small mode, c4 is cleared.
- R9: Reset selects small mode with the carried errors, envelope and counters cleared. It also sets all sub-words to zero, pd4_o = pd16_o = 1 and out_valid = 0.
- R10: out_valid rises exactly one cycle after each sample with in_valid high. Cycles with in_valid low change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_code | input | DW | Signed quantizer code |
| out_valid | output | 1 | Output sample strobe |
| seg1_o | output | DW | Signed 1x segment word |
| seg4_o | output | DW | Signed 4x segment word |
| seg16_o | output | DW | Signed 16x segment word |
| pd4_o | output | 1 | 4x segment powered down |
| pd16_o | output | 1 | 16x segment powered down |

## Verification
A corrupted carried error keeps the weighted sum exact, so it cannot be seen in the sum. It shows up instead as a wrong split between the sub-words on the next valid sample, so every field is compared against a reference model on every sample. A wrong envelope or hold count may show at the ports only hundreds of samples later, as a power-down flag that changes one sample early or late. For that reason the long decay tails, and the bursts that break a hold run, are checked sample by sample. A fault in the drop from large to mid mode surfaces through the 4x and 1x words in the mid-mode samples that follow it.

// File: rtl/dac_seg_split.sv
module dac_seg_split #(
  parameter int DW   = 8,
  parameter int K    = 2,
  parameter int T1   = 15,
  parameter int T2   = 63,
  parameter int HYST = 4,
  parameter int HOLD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_code,
  output logic          out_valid,
  output logic [DW-1:0] seg1_o,
  output logic [DW-1:0] seg4_o,
  output logic [DW-1:0] seg16_o,
  output logic          pd4_o,
  output logic          pd16_o
);
  localparam int IW  = DW + 4;
  localparam int HCW = $clog2(HOLD + 1);
  localparam logic [1:0] M_SMALL = 2'd0, M_MID = 2'd1, M_LARGE = 2'd2;
  localparam logic signed [IW-1:0] RND16 = 8;
  localparam logic signed [IW-1:0] RND4  = 2;

  logic [1:0]     mode_q, mode_d, need, m;
  logic [DW-1:0]  env_q, env_d, mag, peak;
  logic [K-1:0]   dcnt_q;
  logic [HCW-1:0] hold_q, hold_d;
  logic [IW-1:0]  pk_h;
  logic           dn;
  logic signed [IW-1:0] x, c16_q, c4_q, c16_d, c4_d;
  logic signed [IW-1:0] v16, y16, e16, r16, v4, y4, e4, y1;

  assign x    = {{(IW-DW){in_code[DW-1]}}, in_code};
  assign mag  = in_code[DW-1] ? DW'(-in_code) : in_code;
  assign peak = (mag > env_q) ? mag : env_q;
  assign need = (peak > DW'(T2)) ? M_LARGE : (peak > DW'(T1)) ? M_MID : M_SMALL;
  assign m    = (need > mode_q) ? need : mode_q;
  assign pk_h = IW'(peak) + IW'(HYST);
  assign dn   = (mode_q == M_LARGE && pk_h <= IW'(T2)) ||
                (mode_q == M_MID   && pk_h <= IW'(T1));

  always_comb begin
    v16 = x + c16_q;
    y16 = '0;
    if (m == M_LARGE) y16 = (v16 + RND16) >>> 4;
    e16 = v16 - (y16 <<< 4);
    r16 = x - (y16 <<< 4);
    v4  = r16 + c4_q;
    y4  = '0;
    if (m != M_SMALL) y4 = (v4 + RND4) >>> 2;
    e4  = v4 - (y4 <<< 2);
    y1  = r16 - (y4 <<< 2);
  end

  always_comb begin
    mode_d = mode_q;
    hold_d = '0;
    if (need > mode_q) mode_d = need;
    else if (dn) begin
      if (hold_q == HCW'(HOLD - 1)) mode_d = mode_q - 2'd1;
      else hold_d = hold_q + 1'b1;
    end
    c16_d = '0;
    c4_d  = '0;
    if (m == M_LARGE && mode_d == M_MID) c4_d = e4 + e16;
    else if (m == M_LARGE) begin
      c16_d = e16;
      c4_d  = e4;
    end else if (m == M_MID && mode_d == M_MID) c4_d = e4;
    if (mag >= env_q) env_d = mag;
    else if (&dcnt_q) env_d = env_q - 1'b1;
    else env_d = env_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_SMALL;
      env_q     <= '0;
      dcnt_q    <= '0;
      hold_q    <= '0;
      c16_q     <= '0;
      c4_q      <= '0;
      out_valid <= 1'b0;
      seg1_o    <= '0;
      seg4_o    <= '0;
      seg16_o   <= '0;
      pd4_o     <= 1'b1;
      pd16_o    <= 1'b1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mode_q  <= mode_d;
        env_q   <= env_d;
        dcnt_q  <= dcnt_q + 1'b1;
        hold_q  <= hold_d;
        c16_q   <= c16_d;
        c4_q    <= c4_d;
        seg1_o  <= DW'(y1);
        seg4_o  <= DW'(y4);
        seg16_o <= DW'(y16);
        pd4_o   <= (m == M_SMALL);
        pd16_o  <= (m != M_LARGE);
      end
    end
  end
endmodule

module dac_seg_split_sva #(
  parameter int DW = 8,
  parameter int T2 = 63
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_code,
  input logic          out_valid,
  input logic [DW-1:0] seg1_o,
  input logic [DW-1:0] seg4_o,
  input logic [DW-1:0] seg16_o,
  input logic          pd4_o,
  input logic          pd16_o
);
  int code_v, sum_v, mag_v;
  always_comb begin
    code_v = int'($signed(in_code));
    sum_v  = 16 * int'($signed(seg16_o)) + 4 * int'($signed(seg4_o)) + int'($signed(seg1_o));
    mag_v  = (code_v < 0) ? -code_v : code_v;
  end

  AST_SUM_EXACT: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> sum_v == $past(code_v)); // R1
  AST_SMALL_PASS: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && pd4_o) |-> seg1_o == $past(in_code)); // R3
  AST_OFF4_ZERO: assert property (@(posedge clk) disable iff (!rst_n) pd4_o |-> (seg4_o == '0 && pd16_o)); // R3
  AST_OFF16_ZERO: assert property (@(posedge clk) disable iff (!rst_n) pd16_o |-> seg16_o == '0); // R4
  AST_UPSHIFT_NOW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && mag_v > T2) |=> !pd16_o); // R5
  AST_ONE_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n) $rose(pd16_o) |-> !pd4_o); // R7
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R10
endmodule

bind dac_seg_split dac_seg_split_sva #(.DW(DW), .T2(T2)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
  .out_valid(out_valid), .seg1_o(seg1_o), .seg4_o(seg4_o), .seg16_o(seg16_o),
  .pd4_o(pd4_o), .pd16_o(pd16_o)
);

// File: tb/dac_seg_split_bench.sv
module dac_seg_split_bench;
  localparam int DW = 8, K = 2, T1 = 15, T2 = 63, HYST = 4, HOLD = 8;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_code = '0;
  logic out_valid, pd4_o, pd16_o;
  logic [DW-1:0] seg1_o, seg4_o, seg16_o;

  always #2 clk = ~clk;

  dac_seg_split #(.DW(DW), .K(K), .T1(T1), .T2(T2), .HYST(HYST), .HOLD(HOLD)) u_dac_seg_split (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .seg1_o(seg1_o), .seg4_o(seg4_o), .seg16_o(seg16_o),
    .pd4_o(pd4_o), .pd16_o(pd16_o)
  );

  typedef struct {int x; int s1; int s4; int s16; bit p4; bit p16; int md;} exp_t;
  exp_t sbq[$];
  exp_t got;
  string tg;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int env = 0, dcnt = 0, mode = 0, hold = 0, c16 = 0, c4 = 0;

  function automatic int fdiv(int a, int w);
    if (a >= 0) return a / w;
    return -((-a + w - 1) / w);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic send(int x);
    exp_t e;
    int mg, pk, nd, md, nmode, nhold, v, q16, er16, r, v4, q4, er4;
    @(negedge clk);
    mg = (x < 0) ? -x : x;
    pk = (mg > env) ? mg : env;
    nd = (pk > T2) ? 2 : (pk > T1) ? 1 : 0;
    md = (nd > mode) ? nd : mode;
    q16 = 0; er16 = 0; q4 = 0; er4 = 0;
    if (md == 2) begin
      v = x + c16; q16 = fdiv(v + 8, 16); er16 = v - 16 * q16;
    end
    r = x - 16 * q16;
    if (md >= 1) begin
      v4 = r + c4; q4 = fdiv(v4 + 2, 4); er4 = v4 - 4 * q4;
    end
    nmode = mode; nhold = 0;
    if (nd > mode) nmode = nd;
    else if ((mode == 2 && pk + HYST <= T2) || (mode == 1 && pk + HYST <= T1)) begin
      if (hold == HOLD - 1) nmode = mode - 1;
      else nhold = hold + 1;
    end
    if (md == 2 && nmode == 1) begin c4 = er4 + er16; c16 = 0; end
    else if (md == 2) begin c16 = er16; c4 = er4; end
    else if (md == 1 && nmode == 1) begin c4 = er4; c16 = 0; end
    else begin c4 = 0; c16 = 0; end
    if (mg >= env) env = mg;
    else if (dcnt == (1 << K) - 1) env = env - 1;
    dcnt = (dcnt + 1) % (1 << K);
    mode = nmode; hold = nhold;
    e.x = x; e.s16 = q16; e.s4 = q4; e.s1 = r - 4 * q4;
    e.p4 = (md == 0); e.p16 = (md != 2); e.md = md;
    sbq.push_back(e);
    in_valid = 1'b1;
    in_code = x[DW-1:0];
  endtask

  task automatic gap(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (sbq.size() == 0) check(1'b0, "R10", "out_valid with no pending sample", 1, 0);
      else begin
        got = sbq.pop_front();
        tg = (got.md == 0) ? "R3" : (got.md == 1) ? "R4 R8" : "R2 R8";
        check(int'($signed(seg1_o)) == got.s1, tg, "seg1", int'($signed(seg1_o)), got.s1);
        check(int'($signed(seg4_o)) == got.s4, tg, "seg4", int'($signed(seg4_o)), got.s4);
        check(int'($signed(seg16_o)) == got.s16, tg, "seg16", int'($signed(seg16_o)), got.s16);
        check({pd16_o, pd4_o} == {got.p16, got.p4}, "R5 R6 R7", "pd flags",
              int'({pd16_o, pd4_o}), int'({got.p16, got.p4}));
        check(16 * int'($signed(seg16_o)) + 4 * int'($signed(seg4_o)) + int'($signed(seg1_o)) == got.x,
              "R1", "weighted sum",
              16 * int'($signed(seg16_o)) + 4 * int'($signed(seg4_o)) + int'($signed(seg1_o)), got.x);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R10", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0, "R9", "out_valid", int'(out_valid), 0);
    check(seg1_o == '0 && seg4_o == '0 && seg16_o == '0, "R9", "segments zero",
          int'(seg1_o) + int'(seg4_o) + int'(seg16_o), 0);
    check(pd4_o && pd16_o, "R9", "pd flags", int'({pd16_o, pd4_o}), 3);
    rst_n = 1'b1;
    // R3 small signals
    for (int i = -15; i <= 15; i += 3) send(i);
    gap(3);
    // R4 R5 mid range with upshift in the same sample
    for (int i = 0; i < 24; i++) send((i % 2 == 1) ? 40 - i : -(17 + i));
    send(-20); gap(1); send(55); send(3);
    // R2 large mode, constant and varied inputs
    for (int i = 0; i < 30; i++) send(100);
    send(127); send(-128); send(-128);
    for (int i = 0; i < 40; i++) begin
      send(((i * 37) % 256) - 128);
      if (i % 13 == 5) gap(2); // R10 gaps
    end
    send(99);
    // R6 R7 R8 decay to mid with folded residue
    for (int i = 0; i < 320; i++) begin
      send(0);
      if (i % 50 == 7) gap(1);
    end
    // R7 interrupted hold runs in mid mode
    for (int i = 0; i < 250; i++) send((i % 6 == 0) ? 13 : 0);
    for (int i = 0; i < 80; i++) send((i % 5) - 2);
    send(16); send(-5);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R10", "samples left unanswered", sbq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule